// File: doc/BRIEF.md
# Write-Completion Polling Bus Master

This block drives the byte-wide bus of an electrically erasable memory on behalf of a user on the same chip. The user asks for a burst of one to sixty-four bytes starting at a given address. The block then issues the byte loads back to back, one strobe per byte. All loads stay inside the 64-byte page of the start address, and the low address bits wrap within that page. Once the last load has ended, the memory starts its internal programming cycle. The block does not wait a fixed worst-case time for that cycle. It polls the device with ordinary read cycles until the device shows that it has finished.

Two detection methods can be chosen per request. In data-bit mode, the block remembers bit 7 of the last byte written and re-reads the last address until the returned bit 7 equals it. In toggle mode, the block re-reads and compares bit 6 of each read with bit 6 of the read before it. Two equal values in a row mean the device has stopped toggling and is ready. A watchdog ends the polling with an error indication if completion is not seen within a set multiple of the worst-case programming time. Every bus phase lasts a configurable number of clocks.

Top module: `write_poller`

## Requirements
- R1: After reset, `ready` is 1, `done`, `fail` and `mem_drive` are 0, and `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1.
- R2: Each byte load has three phases of `PHASE_CLKS` clocks each, with chip select low throughout: address and data setup with `mem_we_n` high, then `mem_we_n` low, then `mem_we_n` high. `mem_oe_n` stays high whenever `mem_we_n` is low, and `mem_drive` is 1 during all three phases.
- R3: A request with `req_count` = n writes n+1 bytes, where n ranges from 0 to 63. Byte i goes to address {req_addr[12:6], (req_addr[5:0]+i) mod 64}. Its data is the value on `byte_data` while `byte_idx` = i.
- R4: With `req_toggle` = 0, polling reads the address of the last byte written. Completion is declared on the first read whose bit 7 equals bit 7 of that last byte.
- R5: With `req_toggle` = 1, completion is declared on the first read whose bit 6 equals bit 6 of the previous read of the same request. A single read never completes.
- R6: Each polling read keeps `mem_ce_n` low and `mem_we_n` high, holds `mem_oe_n` low for `PHASE_CLKS` clocks between two `PHASE_CLKS`-clock phases with it high, and samples `mem_din_hi` (data bits 7 and 6) on the last clock of the low phase.
- R7: When a request ends, `done` is 1 for exactly one clock, and `ready` is 1 from that same clock on.
- R8: If polling runs `WC_CLKS`×`TIMEOUT_MULT` clocks without completion, the block returns to idle, pulses `done` together with `fail`, and releases chip select and output enable.
- R9: A request presented while `ready` is 0 is ignored and causes no bus activity.
- R10: Within a burst, consecutive falling edges of `mem_we_n` are exactly 3×`PHASE_CLKS` clocks apart. This keeps every load far inside the device's byte-load window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a burst; taken only while ready |
| req_addr | input | ADDR_W | Address of the first byte |
| req_count | input | PAGE_W | Number of bytes minus one |
| req_toggle | input | 1 | 1 selects toggle polling, 0 selects data-bit polling |
| ready | output | 1 | Idle and able to take a request |
| byte_idx | output | PAGE_W | Index of the byte wanted on byte_data |
| byte_data | input | 8 | Data of byte byte_idx, held while the index is stable |
| done | output | 1 | One-clock end-of-request pulse |
| fail | output | 1 | With done: polling timed out |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | 8 | Write data toward the memory |
| mem_drive | output | 1 | Enable for the write-data drivers |
| mem_din_hi | input | 2 | Data bits 7 and 6 read back from the memory |

## Verification
Bursts of 1, 2, 5, 10 and 64 bytes are run in both polling modes. Some start at offset zero, some in mid-page, and one near the top of a page. The page-crossing start shows whether the offset wraps instead of carrying into the page bits. The full-page burst exercises the largest count. The burst data changes from run to run, so the last byte's bit 7 is sometimes 0 and sometimes 1. This separates a correct complement test from a fixed-polarity one. A memory model in the bench inverts bit 7 and toggles bit 6 while it is busy. It counts how many reads fall after its busy time ends, so completion reported too early and needless extra polls both show up. A device that never finishes checks the timeout window, and a request injected mid-burst checks that busy requests are ignored.

// File: rtl/wpoll_pkg.sv
package wpoll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WSET  = 3'd1,
        ST_WLOW  = 3'd2,
        ST_WHIGH = 3'd3,
        ST_RSET  = 3'd4,
        ST_RLOW  = 3'd5,
        ST_RHIGH = 3'd6
    } poll_state_e;
endpackage

// File: rtl/wpoll_phase_timer.sv
module wpoll_phase_timer #(
    parameter int PHASE_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic last
);
    localparam int CW = $clog2(PHASE_CLKS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = CW'(PHASE_CLKS - 1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/wpoll_detect.sv
module wpoll_detect (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       take,
    input  logic       toggle_mode,
    input  logic       ref7,
    input  logic [1:0] smp,
    output logic       hit
);
    typedef struct packed {
        logic prev6;
        logic have;
    } det_t;

    det_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.have = 1'b0;
        end else if (take) begin
            r_d.prev6 = smp[0];
            r_d.have  = 1'b1;
        end
        if (toggle_mode) hit = r_q.have && (smp[0] == r_q.prev6);
        else             hit = (smp[1] == ref7);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/wpoll_watchdog.sv
module wpoll_watchdog #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int WW = $clog2(LIMIT + 1);

    logic [WW-1:0] cnt_d, cnt_q;

    assign expired = run && (cnt_q == WW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run)         cnt_d = '0;
        else if (!expired) cnt_d = cnt_q + WW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/write_poller.sv
module write_poller
    import wpoll_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int PAGE_W       = 6,
    parameter int PHASE_CLKS   = 2,
    parameter int WC_CLKS      = 1_000_000,
    parameter int TIMEOUT_MULT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PAGE_W-1:0] req_count,
    input  logic              req_toggle,
    output logic              ready,
    output logic [PAGE_W-1:0] byte_idx,
    input  logic [7:0]        byte_data,
    output logic              done,
    output logic              fail,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_dout,
    output logic              mem_drive,
    input  logic [1:0]        mem_din_hi
);
    localparam int TIMEOUT_CLKS = WC_CLKS * TIMEOUT_MULT;
    localparam int LOAD_GAP     = 3 * PHASE_CLKS;

    typedef struct packed {
        poll_state_e       st;
        logic [ADDR_W-1:0] base;
        logic [PAGE_W-1:0] last;
        logic [PAGE_W-1:0] idx;
        logic              toggle;
        logic              ref7;
        logic              hit;
        logic              done;
        logic              fail;
    } regs_t;

    regs_t r_d, r_q;
    logic  phase_last, take, det_hit, polling, writing, wd_expired, restart;

    assign polling = (r_q.st == ST_RSET) || (r_q.st == ST_RLOW) || (r_q.st == ST_RHIGH);
    assign writing = (r_q.st == ST_WSET) || (r_q.st == ST_WLOW) || (r_q.st == ST_WHIGH);
    assign restart = (r_d.st != r_q.st) || (r_q.st == ST_IDLE);

    wpoll_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .last(phase_last)
    );

    wpoll_detect u_detect (
        .clk(clk), .rst_n(rst_n), .clear(r_q.st == ST_IDLE), .take(take),
        .toggle_mode(r_q.toggle), .ref7(r_q.ref7), .smp(mem_din_hi), .hit(det_hit)
    );

    wpoll_watchdog #(.LIMIT(TIMEOUT_CLKS)) u_wd (
        .clk(clk), .rst_n(rst_n), .run(polling), .expired(wd_expired)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.fail = 1'b0;
        take     = 1'b0;
        unique case (r_q.st)
            ST_IDLE: if (req) begin
                r_d.st     = ST_WSET;
                r_d.base   = req_addr;
                r_d.last   = req_count;
                r_d.idx    = '0;
                r_d.toggle = req_toggle;
                r_d.hit    = 1'b0;
            end
            ST_WSET: if (phase_last) r_d.st = ST_WLOW;
            ST_WLOW: if (phase_last) r_d.st = ST_WHIGH;
            ST_WHIGH: if (phase_last) begin
                if (r_q.idx == r_q.last) begin
                    r_d.ref7 = byte_data[7];
                    r_d.st   = ST_RSET;
                end else begin
                    r_d.idx = r_q.idx + PAGE_W'(1);
                    r_d.st  = ST_WSET;
                end
            end
            ST_RSET: if (phase_last) r_d.st = ST_RLOW;
            ST_RLOW: if (phase_last) begin
                take    = 1'b1;
                r_d.hit = det_hit;
                r_d.st  = ST_RHIGH;
            end
            ST_RHIGH: if (phase_last) begin
                if (r_q.hit) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.st = ST_RSET;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (wd_expired && r_d.st != ST_IDLE) begin
            r_d.st   = ST_IDLE;
            r_d.done = 1'b1;
            r_d.fail = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ready     = (r_q.st == ST_IDLE);
    assign byte_idx  = r_q.idx;
    assign done      = r_q.done;
    assign fail      = r_q.fail;
    assign mem_ce_n  = (r_q.st == ST_IDLE);
    assign mem_we_n  = (r_q.st != ST_WLOW);
    assign mem_oe_n  = (r_q.st != ST_RLOW);
    assign mem_drive = writing;
    assign mem_dout  = byte_data;
    assign mem_addr  = {r_q.base[ADDR_W-1:PAGE_W], r_q.base[PAGE_W-1:0] + r_q.idx};

    // load-spacing monitor used only by the assertion below
    logic [15:0] gap_q;
    logic        seen_q, we_prev_q;
    always_ff @(posedge clk) begin
        if (!rst_n || r_q.st == ST_IDLE) begin
            gap_q <= '0; seen_q <= 1'b0; we_prev_q <= 1'b1;
        end else begin
            we_prev_q <= mem_we_n;
            if (!mem_we_n && we_prev_q) begin
                gap_q <= '0; seen_q <= 1'b1;
            end else if (gap_q != 16'hFFFF) begin
                gap_q <= gap_q + 16'd1;
            end
        end
    end

    // R2
    oe_high_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));
    // R6
    read_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n && !mem_drive));
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3
    page_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (writing && $past(writing)) |-> $stable(mem_addr[ADDR_W-1:PAGE_W]));
    // R8
    fail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (done && mem_ce_n && mem_oe_n));
    // R10
    load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && we_prev_q && seen_q) |-> (gap_q == 16'(LOAD_GAP - 1)));
endmodule

// File: tb/write_poller_test.sv
`timescale 1ns/1ps
module write_poller_test;
    localparam int PH = 2;
    localparam int WCP = 1000;
    localparam int MULT = 3;
    localparam int TO = WCP * MULT;
    localparam int BUSY = 300;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req = 1'b0, req_toggle = 1'b0;
    logic [12:0] req_addr = '0;
    logic [5:0]  req_count = '0, byte_idx;
    logic [7:0]  byte_data, mem_dout, din_full;
    logic ready, done, fail, mem_ce_n, mem_oe_n, mem_we_n, mem_drive;
    logic [12:0] mem_addr;

    int checks = 0, failures = 0;
    int run_id = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(input int run, input int k);
        return 8'((k * 29 + run * 83 + 7) ^ (run << 7));
    endfunction
    function automatic logic [12:0] eaddr(input logic [12:0] b, input int k);
        return {b[12:6], 6'(b[5:0] + 6'(k))};
    endfunction

    assign byte_data = pat(run_id, int'(byte_idx));

    write_poller #(.PHASE_CLKS(PH), .WC_CLKS(WCP), .TIMEOUT_MULT(MULT)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_count(req_count),
        .req_toggle(req_toggle), .ready(ready), .byte_idx(byte_idx), .byte_data(byte_data),
        .done(done), .fail(fail), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_drive(mem_drive), .mem_din_hi(din_full[7:6]));

    // memory model
    logic [7:0] model_mem [0:8191];
    logic [7:0] last_d = '0;
    logic [12:0] cur_base = '0;
    int busy = 0, we_w = 0, cyc = 0, last_rise = 0, last_fall = -1;
    int wr_cnt = 0, wr_bad = 0, ph_bad = 0, rd_bad = 0, rd_cnt = 0, clean = 0, gap_bad = 0;
    logic tog = 1'b0, stuck = 1'b0, we_p = 1'b1, oe_p = 1'b1;

    assign din_full = (busy != 0) ? {~last_d[7], tog, last_d[5:0]} : model_mem[mem_addr];

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        we_p <= mem_we_n;
        oe_p <= mem_oe_n;
        if (we_p && !mem_we_n) begin
            if (last_fall >= 0 && cyc - last_fall != 3 * PH) gap_bad <= gap_bad + 1;
            last_fall <= cyc;
        end
        if (!we_p && mem_we_n) begin
            if (mem_addr != eaddr(cur_base, wr_cnt) || mem_dout != pat(run_id, wr_cnt)) wr_bad <= wr_bad + 1;
            if (we_w != PH || !mem_drive) ph_bad <= ph_bad + 1;
            model_mem[mem_addr] <= mem_dout;
            last_d    <= mem_dout;
            busy      <= BUSY;
            wr_cnt    <= wr_cnt + 1;
            last_rise <= cyc;
            we_w      <= 0;
        end else begin
            if (!mem_we_n) begin
                we_w <= we_w + 1;
                if (!mem_oe_n || mem_ce_n) ph_bad <= ph_bad + 1;
            end
            if (busy != 0 && !stuck) busy <= busy - 1;
        end
        if (oe_p && !mem_oe_n) begin
            rd_cnt <= rd_cnt + 1;
            if (busy != 0) tog <= ~tog;
            else           clean <= clean + 1;
            if (!mem_we_n || mem_ce_n) rd_bad <= rd_bad + 1;
        end
    end

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic do_run(input logic mode, input logic [12:0] base, input int cnt, input logic exp_fail);
        int n;
        logic [12:0] last_a;
        @(negedge clk);
        run_id++;
        cur_base = base;
        wr_cnt = 0; wr_bad = 0; ph_bad = 0; rd_bad = 0; rd_cnt = 0; clean = 0; gap_bad = 0;
        last_fall = -1;
        last_a = eaddr(base, cnt);
        req = 1'b1; req_addr = base; req_count = 6'(cnt); req_toggle = mode;
        @(negedge clk);
        req = 1'b0;
        chk(!ready, "R9 ready low after accept", int'(ready), 0);
        repeat (4) @(negedge clk);
        req = 1'b1; req_addr = 13'h1FFF; req_count = 6'd7; req_toggle = ~mode;
        @(negedge clk);
        req = 1'b0;
        n = 0;
        while (!done && n < 20000) begin
            if (!mem_oe_n && mem_addr != last_a) rd_bad++;
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R7 done seen", int'(done), 1);
        chk(fail == exp_fail, "R8 fail flag", int'(fail), int'(exp_fail));
        chk(ready == 1'b1, "R7 ready with done", int'(ready), 1);
        chk(wr_cnt == cnt + 1, "R3 byte loads", wr_cnt, cnt + 1);
        chk(wr_bad == 0, "R3 load address/data", wr_bad, 0);
        chk(ph_bad == 0, "R2 strobe width/oe", ph_bad, 0);
        chk(gap_bad == 0, "R10 load spacing", gap_bad, 0);
        chk(model_mem[13'h1FFF] == 8'h00, "R9 ignored request wrote", int'(model_mem[13'h1FFF]), 0);
        if (exp_fail) begin
            chk(mem_ce_n && mem_oe_n, "R8 bus released", int'(mem_ce_n & mem_oe_n), 1);
            chk(cyc - last_rise >= TO && cyc - last_rise <= TO + 6, "R8 timeout latency", cyc - last_rise, TO);
        end else begin
            chk(busy == 0, "R4/R5 not early (busy left)", busy, 0);
            chk(rd_bad == 0, "R6 read cycle shape/address", rd_bad, 0);
            if (mode) begin
                chk(clean <= 2, "R5 extra clean polls", clean, 2);
                chk(rd_cnt >= 2, "R5 at least two reads", rd_cnt, 2);
            end else begin
                chk(clean <= 1, "R4 extra clean polls", clean, 1);
            end
            for (int k = 0; k <= cnt; k++)
                if (model_mem[eaddr(base, k)] != pat(run_id, k))
                    chk(1'b0, "R3 stored byte", int'(model_mem[eaddr(base, k)]), int'(pat(run_id, k)));
        end
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL R7 watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int a = 0; a < 8192; a++) model_mem[a] = 8'h00;
        repeat (4) @(negedge clk);
        chk(ready == 1'b1, "R1 ready", int'(ready), 1);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high", int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
        chk(!done && !fail && !mem_drive, "R1 done/fail/drive low", int'({done, fail, mem_drive}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1 && mem_ce_n, "R1 idle after reset", int'(ready), 1);
        for (int m = 0; m < 2; m++) begin
            do_run(m[0], 13'h0040, 0, 1'b0);
            do_run(m[0], 13'h0105, 1, 1'b0);
            do_run(m[0], 13'h0391, 4, 1'b0);
            do_run(m[0], 13'h0A7C, 9, 1'b0);
            do_run(m[0], 13'h0F00, 63, 1'b0);
        end
        stuck = 1'b1;
        do_run(1'b0, 13'h0200, 0, 1'b1);
        stuck = 1'b0;
        repeat (BUSY + 20) @(negedge clk);
        do_run(1'b1, 13'h0233, 2, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule